// File: doc/BRIEF.md
# Maximum Duty Limiter for a Buck Gate Command

This block sits between the PWM comparator of a current-mode buck controller and the high-side gate driver. It takes the period-start strobe from the oscillator, the comparator's request to end the on-time, and an overcurrent blank. From these it produces a registered gate command and a flag showing which of its two duty modes is active. All timing is counted in system-clock cycles. The length of the switching period is measured from the strobes, so the block follows an external clock as well as the free-running one.

In steady mode every period ends with a short forced-off window. This leaves the bootstrap capacitor a gap in which to recharge and caps duty at roughly 91% for a 300 kHz period. When the comparator has still not asked for turn-off by the time that window opens, the block switches to burst mode. In burst mode the switch may stay on across period boundaries for a run of eight periods. The last period of the run then ends with a longer forced-off gap, so the switch opens once per eight periods. Any period in which the on-time is cut short by a request returns the block to steady mode from the next period. A minimum on-time defers early comparator requests. The overcurrent blank overrides every other input.

Top module: `duty_limiter`

## Requirements
- R1: In steady mode the gate is low for at least the last OFF_STEADY cycles of every period. The window opens at offset L-OFF_STEADY, where L is the period length in cycles, and a request landing exactly on that offset still leaves the block in steady mode.
- R2: A turn-off request sampled at offset j (j >= MIN_ON, before the window) makes the gate low from the next cycle on, so the on-time is exactly j cycles. The gate stays low until the next period start.
- R3: A turn-off request sampled at an offset below MIN_ON is held. The gate falls at offset MIN_ON, giving an on-time of MIN_ON cycles.
- R4: An overcurrent blank sampled at offset k turns the gate low from the next cycle until the next period start, giving an on-time of k cycles. This holds even inside the minimum on-time, and k = 0 gives no pulse.
- R5: When no turn-off request has been seen up to and including the window-opening edge, the mode flag rises at that edge (1 = burst, 0 = steady) and the gate stays high through the rest of the period.
- R6: In burst mode, the gate stays high across period boundaries for periods 1 to 7 of a run, counting the entry period as 1. In period 8 it is low for the last OFF_BURST cycles, and the next period starts a new run.
- R7: With no requests in burst mode, the gate has exactly one rising edge per BURST_LEN periods.
- R8: A period in burst mode whose on-time is ended by a turn-off request or by the overcurrent blank makes the mode flag 0 from the next period start.
- R9: The window offsets come from the length of the previous period. Until a full period has been measured after reset, NOM_PERIOD is used instead.
- R10: Reset clears the gate and the mode flag. The gate only rises at the edge that samples a period-start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_start | input | 1 | One-cycle strobe opening each switching period |
| cmp_off | input | 1 | PWM comparator request to end the on-time |
| ocp_blank | input | 1 | Overcurrent blank, forces the gate off |
| gate_on | output | 1 | Registered high-side gate command |
| max_duty_mode | output | 1 | Registered mode flag, 1 = burst mode |

## Verification
The bench builds the block with a nominal period of 20 cycles, a steady-mode window of 3 cycles, a burst-mode gap of 7 cycles, a minimum on-time of 2 cycles and a run of 8 periods. At these sizes every request offset across a whole period can be swept in about twenty periods. Two full eight-period runs, the mode exits and a change of period length to 30 cycles also fit in a few thousand cycles. Expected on-times are computed in the bench as max(j, MIN_ON), L-OFF_STEADY, L-OFF_BURST or k, and are compared against gate-high counts taken per period.

// File: rtl/dlim_pkg.sv
package dlim_pkg;
  typedef enum logic {
    DL_STEADY = 1'b0,
    DL_BURST  = 1'b1
  } dl_mode_e;
endpackage

// File: rtl/dlim_period_track.sv
// Tracks the position inside the switching period and the length of the
// previous period, and derives where the two forced-off windows open.
module dlim_period_track #(
  parameter int CNT_W      = 16,
  parameter int NOM_PERIOD = 667,
  parameter int OFF_STEADY = 60,
  parameter int OFF_BURST  = 140
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  output logic [CNT_W-1:0] np,
  output logic [CNT_W-1:0] pos_q,
  output logic [CNT_W-1:0] edge_s,
  output logic             win_s_start,
  output logic             win_s_hit,
  output logic             win_b_hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] NOM_C   = CNT_W'(NOM_PERIOD);
  localparam logic [CNT_W-1:0] OFFS_C  = CNT_W'(OFF_STEADY);
  localparam logic [CNT_W-1:0] OFFB_C  = CNT_W'(OFF_BURST);

  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] pos_inc;
  logic [CNT_W-1:0] edge_b;
  logic             seen_q;

  always_comb begin
    pos_inc = (pos_q == CNT_MAX) ? CNT_MAX : pos_q + 1'b1;
    np      = strobe ? '0 : pos_inc;
    edge_s  = (len_q > OFFS_C) ? len_q - OFFS_C : '0;
    edge_b  = (len_q > OFFB_C) ? len_q - OFFB_C : '0;
  end

  assign win_s_start = (np == edge_s);
  assign win_s_hit   = (np >= edge_s);
  assign win_b_hit   = (np >= edge_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      len_q  <= NOM_C;
      seen_q <= 1'b0;
    end else begin
      pos_q <= np;
      if (strobe) begin
        seen_q <= 1'b1;
        if (seen_q) len_q <= pos_inc;
      end
    end
  end

  AST_LEN_ONLY_AT_STROBE: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(len_q)); // R9
endmodule

// File: rtl/dlim_gate_ctl.sv
// Gate command register with held turn-off request, minimum on-time and
// overcurrent override.
module dlim_gate_ctl #(
  parameter int CNT_W  = 16,
  parameter int MIN_ON = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             cmp_off,
  input  logic             ocp_blank,
  input  logic [CNT_W-1:0] np,
  input  logic             window_hit,
  output logic             gate_q,
  output logic             off_pend_q,
  output logic             ended_q
);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_ON);

  logic past_min;
  logic req_any;
  logic cut_req;
  logic gate_d;

  always_comb begin
    past_min = (np >= MIN_C);
    req_any  = cmp_off | off_pend_q;
    cut_req  = !strobe && gate_q && (ocp_blank || (req_any && past_min));
    gate_d   = !ocp_blank &&
               (strobe || (gate_q && (!past_min || (!req_any && !window_hit))));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q     <= 1'b0;
      off_pend_q <= 1'b0;
      ended_q    <= 1'b0;
    end else begin
      gate_q     <= gate_d;
      off_pend_q <= strobe ? 1'b0 : (off_pend_q | cmp_off);
      ended_q    <= strobe ? 1'b0 : (ended_q | cut_req);
    end
  end

  AST_OCP_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
    ocp_blank |=> !gate_q); // R4
  AST_MIN_ON_HELD: assert property (@(posedge clk) disable iff (rst)
    (gate_q && !ocp_blank && !strobe && np < MIN_C) |=> gate_q); // R3
  AST_RISE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_q) |-> $past(strobe)); // R10
endmodule

// File: rtl/dlim_burst_ctl.sv
// Mode state and burst-run period counter.
module dlim_burst_ctl
  import dlim_pkg::*;
#(
  parameter int BURST_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic win_s_start,
  input  logic gate_q,
  input  logic cmp_off,
  input  logic off_pend,
  input  logic ocp_blank,
  input  logic ended,
  output logic enter,
  output logic burst_last,
  output logic mode_q
);
  localparam int BW = $clog2(BURST_LEN + 1);
  localparam logic [BW-1:0] LAST_C = BW'(BURST_LEN);
  localparam logic [BW-1:0] ONE_C  = BW'(1);

  dl_mode_e        mode_r;
  logic [BW-1:0]   bcnt_q;

  always_comb begin
    enter = (mode_r == DL_STEADY) && !strobe && win_s_start && gate_q &&
            !cmp_off && !off_pend && !ocp_blank;
    burst_last = (mode_r == DL_BURST) && (bcnt_q == LAST_C);
    mode_q     = (mode_r == DL_BURST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r <= DL_STEADY;
      bcnt_q <= '0;
    end else if (enter) begin
      mode_r <= DL_BURST;
      bcnt_q <= ONE_C;
    end else if (strobe && mode_r == DL_BURST) begin
      if (ended) begin
        mode_r <= DL_STEADY;
        bcnt_q <= '0;
      end else begin
        bcnt_q <= (bcnt_q == LAST_C) ? ONE_C : bcnt_q + 1'b1;
      end
    end
  end

  AST_RUN_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (mode_r == DL_BURST) |-> (bcnt_q >= ONE_C && bcnt_q <= LAST_C)); // R6
  AST_EXIT_AT_STROBE: assert property (@(posedge clk) disable iff (rst)
    $fell(mode_q) |-> $past(strobe)); // R8
  AST_ENTRY_INSIDE_PERIOD: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_q) |-> !$past(strobe)); // R5
endmodule

// File: rtl/duty_limiter.sv
module duty_limiter #(
  parameter int CNT_W      = 16,
  parameter int NOM_PERIOD = 667,
  parameter int OFF_STEADY = 60,
  parameter int OFF_BURST  = 140,
  parameter int MIN_ON     = 40,
  parameter int BURST_LEN  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic period_start,
  input  logic cmp_off,
  input  logic ocp_blank,
  output logic gate_on,
  output logic max_duty_mode
);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_ON);

  logic [CNT_W-1:0] np;
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] edge_s;
  logic             win_s_start, win_s_hit, win_b_hit;
  logic             gate_q, off_pend_q, ended_q;
  logic             enter, burst_last, mode_q;
  logic             window_hit;

  dlim_period_track #(
    .CNT_W(CNT_W), .NOM_PERIOD(NOM_PERIOD),
    .OFF_STEADY(OFF_STEADY), .OFF_BURST(OFF_BURST)
  ) track_i (
    .clk(clk), .rst(rst), .strobe(period_start),
    .np(np), .pos_q(pos_q), .edge_s(edge_s),
    .win_s_start(win_s_start), .win_s_hit(win_s_hit), .win_b_hit(win_b_hit)
  );

  always_comb begin
    if (!mode_q) window_hit = win_s_hit && !enter;
    else         window_hit = burst_last && win_b_hit;
  end

  dlim_gate_ctl #(.CNT_W(CNT_W), .MIN_ON(MIN_ON)) gate_i (
    .clk(clk), .rst(rst), .strobe(period_start), .cmp_off(cmp_off),
    .ocp_blank(ocp_blank), .np(np), .window_hit(window_hit),
    .gate_q(gate_q), .off_pend_q(off_pend_q), .ended_q(ended_q)
  );

  dlim_burst_ctl #(.BURST_LEN(BURST_LEN)) burst_i (
    .clk(clk), .rst(rst), .strobe(period_start), .win_s_start(win_s_start),
    .gate_q(gate_q), .cmp_off(cmp_off), .off_pend(off_pend_q),
    .ocp_blank(ocp_blank), .ended(ended_q),
    .enter(enter), .burst_last(burst_last), .mode_q(mode_q)
  );

  assign gate_on       = gate_q;
  assign max_duty_mode = mode_q;

  AST_STEADY_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (gate_q && pos_q >= edge_s && pos_q >= MIN_C) |-> mode_q); // R1
endmodule

// File: tb/duty_limiter_tb_top.sv
`timescale 1ns/1ps
module duty_limiter_tb_top;
  localparam int P    = 20;
  localparam int OS   = 3;
  localparam int OB   = 7;
  localparam int TMIN = 2;
  localparam int BL   = 8;
  localparam int W1   = P - OS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic period_start = 1'b0;
  logic cmp_off = 1'b0;
  logic ocp_blank = 1'b0;
  logic gate_on, max_duty_mode;

  int checks = 0;
  int fails = 0;
  int prev_gate = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  duty_limiter #(
    .CNT_W(8), .NOM_PERIOD(P), .OFF_STEADY(OS), .OFF_BURST(OB),
    .MIN_ON(TMIN), .BURST_LEN(BL)
  ) dut_i (
    .clk(clk), .rst(rst), .period_start(period_start), .cmp_off(cmp_off),
    .ocp_blank(ocp_blank), .gate_on(gate_on), .max_duty_mode(max_duty_mode)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One period of length len; request / blank at the given offsets (-1 = none).
  task automatic run_period(input int len, input int cmp_at, input int ocp_at,
                            output int on_cnt, output int m_first,
                            output int m_last, output int rises);
    on_cnt = 0; rises = 0; m_first = 0; m_last = 0;
    for (int c = 0; c < len; c++) begin
      period_start = (c == 0);
      cmp_off      = (c == cmp_at);
      ocp_blank    = (c == ocp_at);
      @(posedge clk);
      @(negedge clk);
      on_cnt += int'(gate_on);
      if (gate_on && prev_gate == 0) rises++;
      prev_gate = int'(gate_on);
      if (c == 0) m_first = int'(max_duty_mode);
      m_last = int'(max_duty_mode);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int on, mf, ml, r, rise_sum;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset gate", int'(gate_on), 0);
    check("R10 reset mode", int'(max_duty_mode), 0);
    rst = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R10 no rise without strobe", int'(gate_on), 0);

    // Sweep of request offsets in steady mode (R1, R2, R3, nominal length R9)
    for (int j = 1; j <= W1; j++) begin
      run_period(P, j, -1, on, mf, ml, r);
      if (j < TMIN)      check($sformatf("R3 held request j=%0d", j), on, TMIN);
      else if (j == W1)  check("R1 window edge request", on, W1);
      else               check($sformatf("R2 cut j=%0d", j), on, j);
      check($sformatf("R5 stays steady j=%0d", j), ml, 0);
    end

    // Entry into burst mode
    run_period(P, -1, -1, on, mf, ml, r);
    check("R5 entry period on-time", on, P);
    check("R5 entry mode flag", ml, 1);
    rise_sum = 0;
    for (int k = 2; k <= 17; k++) begin
      run_period(P, -1, -1, on, mf, ml, r);
      check($sformatf("R6 run period %0d", k), on, (k % BL == 0) ? P - OB : P);
      check($sformatf("R6 mode period %0d", k), ml, 1);
      rise_sum += r;
    end
    check("R7 rising edges over 16 periods", rise_sum, 16 / BL);

    // Return to steady by a request
    run_period(P, 9, -1, on, mf, ml, r);
    check("R8 cut inside burst", on, 9);
    check("R8 mode held in cut period", ml, 1);
    run_period(P, 5, -1, on, mf, ml, r);
    check("R8 steady after cut", mf, 0);
    check("R2 cut after return", on, 5);

    // Overcurrent blank in steady mode
    for (int k = 0; k <= 4; k++) begin
      run_period(P, 10, k, on, mf, ml, r);
      check($sformatf("R4 blank at %0d", k), on, k);
      check($sformatf("R4 mode steady %0d", k), ml, 0);
    end

    // Overcurrent blank in burst mode
    run_period(P, -1, -1, on, mf, ml, r);
    check("R5 re-entry", ml, 1);
    run_period(P, -1, 6, on, mf, ml, r);
    check("R4 blank inside burst", on, 6);
    run_period(P, 5, -1, on, mf, ml, r);
    check("R8 steady after blank", mf, 0);
    check("R2 cut after blank exit", on, 5);

    // Period length change to 30 cycles
    run_period(30, 17, -1, on, mf, ml, r);
    check("R9 old length still used", on, 17);
    check("R9 old length no entry", ml, 0);
    run_period(30, 27, -1, on, mf, ml, r);
    check("R9 new window edge", on, 27);
    check("R9 new window no entry", ml, 0);
    run_period(30, 28, -1, on, mf, ml, r);
    check("R9 request past new window", on, 28);
    check("R9 entry at new window", ml, 1);
    run_period(30, 5, -1, on, mf, ml, r);
    check("R8 steady after late request", mf, 0);

    period_start = 1'b0; cmp_off = 1'b0; ocp_blank = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule